// File: doc/BRIEF.md
# Prescaled Timekeeping Counter with Match Compare

This block keeps time from a slow reference clock, nominally 32.768 kHz. A prescaler divides the reference by a parameter (128 by default), so each count lasts about 3.90625 ms. Every prescaler period advances a wide up-counter (40 bits by default). A match register is compared with the counter. The comparison drives two identical match outputs, which can be gated off. It can also clear the counter, so the block acts as a periodic wake timer.

Software reaches the block through a simple write port in a separate bus-clock domain. That port loads three values:
- an 8-bit control word;
- the match value;
- a counter preset.

Control bits cross into the reference domain through two-flop synchronizers. The wide match and preset values cross with a toggle handshake. Two oscillator controls are passed straight through as outputs: a 2-bit mode field and an oscillator-select bit.

Top module: `rtc_match_counter`

## Requirements
- R1: While running, the counter increases by exactly 1 every PRESC_DIV reference-clock rising edges. Running means all three of these hold after synchronization: counter enable (bit 6) is 1, the internal block reset is 0, and the counter-clear-n bit (bit 1) is 1.
- R2: The control word has this bit layout: 7 block reset, 6 counter enable, 5 match-output enable, 4:3 oscillator mode, 2 clear-on-match, 1 counter-clear-n, 0 oscillator select. After reset, all control bits, the counter and the match register are 0.
- R3: While block reset (bit 7) is 1, the counter is held at 0 and does not advance. After bit 7 is written back to 0, the internal reset stays asserted for two more bus-clock cycles.
- R4: After the counter is enabled, the first increment comes FIRST_TICK reference edges after the synchronized enable arrives. This is 2 synchronizer edges plus FIRST_TICK edges after the write.
- R5: Clearing counter enable stops counting and keeps the counter value. A preset write (wr_sel=2) loads the counter only while it is disabled. While it is enabled, a preset write is ignored.
- R6: When match-output enable (bit 5) is 1, both match outputs are 1 exactly while the counter equals the match register (written with wr_sel=1). When bit 5 is 0, both outputs stay 0.
- R7: When clear-on-match (bit 2) is 1 and the match value is nonzero, the tick that finds the counter equal to the match value sets the counter to 0 instead of incrementing it. When the match value is all zeros, this clear is disabled.
- R8: Writing 0 to counter-clear-n (bit 1) forces the counter to 0 and holds it there.
- R9: osc_sel_o equals bit 0. osc_mode_o equals bits 4:3 when bit 0 is 1, and 0 otherwise. A control write uses wr_sel=0 and wr_data[7:0]. wr_sel=3 is ignored.
- R10: Without a match clear, the counter wraps from all ones to 0.
- R11: With match value 0xE1000, the match outputs rise exactly one prescaler period after the counter reaches 0xE1000-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Write-port clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 control, 1 match, 2 preset, 3 none |
| wr_data | input | CNT_W | Write data (control uses bits 7:0) |
| ref_clk | input | 1 | Reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| count_o | output | CNT_W | Current counter value |
| match_o | output | 1 | Gated match indication |
| match_aux_o | output | 1 | Second copy of the gated match indication |
| osc_mode_o | output | 2 | Oscillator mode, forced to 0 unless select is set |
| osc_sel_o | output | 1 | Oscillator select |

## Verification
The bench builds the block with CNT_W at its default of 40 and the synchronizer depth at 2. It shortens PRESC_DIV to 8 and FIRST_TICK to 4, so every tick interval, the first-tick delay and the clear-on-match step can be seen within a few dozen reference cycles. Presets near the top of the 40-bit range and just below 0xE1000 bring the wrap and the 0xE1000 match within reach without counting through the full range. The cycle-exact prescaler interval is still measured at each of these points.

// File: rtl/rtcm_pkg.sv
package rtcm_pkg;

    // Control word; the field order is the bit layout software writes.
    typedef struct packed {
        logic       blk_rst;
        logic       cnt_en;
        logic       match_en;
        logic [1:0] xt_mode;
        logic       rst_on_match;
        logic       cnt_rst_n;
        logic       osc_en;
    } rtc_ctrl_t;

    localparam int CTRL_W = $bits(rtc_ctrl_t);

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_MATCH   = 2'd1,
        SEL_PRELOAD = 2'd2,
        SEL_NONE    = 2'd3
    } wr_sel_e;

    // Subset of control that is carried into the reference domain.
    typedef struct packed {
        logic blk_rst;
        logic cnt_en;
        logic match_en;
        logic rst_on_match;
        logic cnt_rst_n;
    } ref_ctrl_t;

    localparam int REF_CTRL_W = $bits(ref_ctrl_t);
    localparam int BLK_HOLD   = 2;

    function automatic logic [1:0] osc_mode_f(rtc_ctrl_t c);
        return c.osc_en ? c.xt_mode : 2'b00;
    endfunction

    function automatic ref_ctrl_t to_ref_f(rtc_ctrl_t c, logic blk_int);
        ref_ctrl_t r;
        r.blk_rst      = blk_int;
        r.cnt_en       = c.cnt_en;
        r.match_en     = c.match_en;
        r.rst_on_match = c.rst_on_match;
        r.cnt_rst_n    = c.cnt_rst_n;
        return r;
    endfunction

endpackage

// File: rtl/rtcm_bus_regs.sv
module rtcm_bus_regs
    import rtcm_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output rtc_ctrl_t        ctrl_o,
    output logic             blk_int_o,
    output logic [CNT_W-1:0] match_hold_o,
    output logic [CNT_W-1:0] preload_hold_o,
    output logic             match_tgl_o,
    output logic             preload_tgl_o
);

    wr_sel_e             sel;
    rtc_ctrl_t           ctrl_q;
    logic [BLK_HOLD-1:0] blk_sh_q;
    logic [CNT_W-1:0]    match_q;
    logic [CNT_W-1:0]    preload_q;
    logic                match_tgl_q;
    logic                preload_tgl_q;

    assign sel = wr_sel_e'(wr_sel);

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            ctrl_q        <= '0;
            blk_sh_q      <= '0;
            match_q       <= '0;
            preload_q     <= '0;
            match_tgl_q   <= 1'b0;
            preload_tgl_q <= 1'b0;
        end else begin
            blk_sh_q <= {blk_sh_q[BLK_HOLD-2:0], ctrl_q.blk_rst};
            if (wr_en) begin
                unique case (sel)
                    SEL_CTRL:    ctrl_q <= rtc_ctrl_t'(wr_data[CTRL_W-1:0]);
                    SEL_MATCH: begin
                        match_q     <= wr_data;
                        match_tgl_q <= ~match_tgl_q;
                    end
                    SEL_PRELOAD: begin
                        preload_q     <= wr_data;
                        preload_tgl_q <= ~preload_tgl_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Internal reset lingers BLK_HOLD bus cycles after the bit drops.
    assign blk_int_o      = ctrl_q.blk_rst | (|blk_sh_q);
    assign ctrl_o         = ctrl_q;
    assign match_hold_o   = match_q;
    assign preload_hold_o = preload_q;
    assign match_tgl_o    = match_tgl_q;
    assign preload_tgl_o  = preload_tgl_q;

endmodule

// File: rtl/rtcm_sync.sv
module rtcm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rtcm_prescaler.sv
module rtcm_prescaler #(
    parameter int PRESC_DIV  = 128,
    parameter int FIRST_TICK = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick_o
);

    localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
    localparam logic [PW-1:0] LIM_FIRST = PW'(FIRST_TICK - 1);
    localparam logic [PW-1:0] LIM_FULL  = PW'(PRESC_DIV - 1);

    logic [PW-1:0] div_q;
    logic          first_q;
    logic          hit;

    assign hit = run && (div_q == (first_q ? LIM_FIRST : LIM_FULL));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q   <= '0;
            first_q <= 1'b1;
        end else if (hit) begin
            div_q   <= '0;
            first_q <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = hit;

endmodule

// File: rtl/rtcm_counter.sv
module rtcm_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             blk_rst,
    input  logic             cnt_rst_n,
    input  logic             cnt_en,
    input  logic             rst_on_match,
    input  logic             match_ld,
    input  logic [CNT_W-1:0] match_val,
    input  logic             pre_ld,
    input  logic [CNT_W-1:0] pre_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] match_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] match_q;
    logic             clr_hit;

    assign clr_hit = rst_on_match && (|match_q) && (cnt_q == match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= '0;
        end else begin
            if (match_ld) begin
                match_q <= match_val;
            end
            if (blk_rst || !cnt_rst_n) begin
                cnt_q <= '0;
            end else if (pre_ld && !cnt_en) begin
                cnt_q <= pre_val;
            end else if (tick) begin
                cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = match_q;

endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
    import rtcm_pkg::*;
#(
    parameter int CNT_W       = 40,
    parameter int PRESC_DIV   = 128,
    parameter int FIRST_TICK  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ref_clk,
    input  logic             ref_rst,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o,
    output logic             match_aux_o,
    output logic [1:0]       osc_mode_o,
    output logic             osc_sel_o
);

    localparam int XW = REF_CTRL_W + 2;

    rtc_ctrl_t        ctrl_q;
    logic             blk_int;
    logic [CNT_W-1:0] match_hold;
    logic [CNT_W-1:0] preload_hold;
    logic             match_tgl;
    logic             preload_tgl;

    rtcm_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .bus_clk        (bus_clk),
        .bus_rst        (bus_rst),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .ctrl_o         (ctrl_q),
        .blk_int_o      (blk_int),
        .match_hold_o   (match_hold),
        .preload_hold_o (preload_hold),
        .match_tgl_o    (match_tgl),
        .preload_tgl_o  (preload_tgl)
    );

    assign osc_sel_o  = ctrl_q.osc_en;
    assign osc_mode_o = osc_mode_f(ctrl_q);

    // Reference-domain crossing
    ref_ctrl_t        rc_s;
    logic [1:0]       tgl_s;
    logic [1:0]       tgl_q;
    logic             match_ld;
    logic             pre_ld;
    logic [XW-1:0]    x_in;
    logic [XW-1:0]    x_out;

    assign x_in = {to_ref_f(ctrl_q, blk_int), match_tgl, preload_tgl};

    rtcm_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (x_in),
        .q   (x_out)
    );

    assign rc_s  = ref_ctrl_t'(x_out[XW-1:2]);
    assign tgl_s = x_out[1:0];

    always_ff @(posedge ref_clk) begin
        if (ref_rst) tgl_q <= '0;
        else         tgl_q <= tgl_s;
    end

    assign match_ld = tgl_s[1] ^ tgl_q[1];
    assign pre_ld   = tgl_s[0] ^ tgl_q[0];

    logic run;
    logic tick;
    logic [CNT_W-1:0] match_q;

    assign run = rc_s.cnt_en && !rc_s.blk_rst && rc_s.cnt_rst_n;

    rtcm_prescaler #(.PRESC_DIV(PRESC_DIV), .FIRST_TICK(FIRST_TICK)) u_presc (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .run    (run),
        .tick_o (tick)
    );

    rtcm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (ref_clk),
        .rst          (ref_rst),
        .tick         (tick),
        .blk_rst      (rc_s.blk_rst),
        .cnt_rst_n    (rc_s.cnt_rst_n),
        .cnt_en       (rc_s.cnt_en),
        .rst_on_match (rc_s.rst_on_match),
        .match_ld     (match_ld),
        .match_val    (match_hold),
        .pre_ld       (pre_ld),
        .pre_val      (preload_hold),
        .cnt_o        (count_o),
        .match_o      (match_q)
    );

    logic hit_eq;
    assign hit_eq      = rc_s.match_en && (count_o == match_q);
    assign match_o     = hit_eq;
    assign match_aux_o = hit_eq;

endmodule

// File: rtl/rtc_match_counter_chk.sv
module rtc_match_counter_chk #(
    parameter int CNT_W = 40
) (
    input logic             bus_clk,
    input logic             bus_rst,
    input logic             ref_clk,
    input logic             ref_rst,
    input logic             blk_bit,
    input logic             blk_int,
    input logic             tick,
    input logic             en_s,
    input logic             blk_s,
    input logic             rstn_s,
    input logic             rom_s,
    input logic             men_s,
    input logic             pre_ld,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] match_reg,
    input logic             match_o,
    input logic             match_aux_o,
    input logic             osc_sel_o,
    input logic [1:0]       osc_mode_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_MATCH_DUAL: assert property (@(posedge ref_clk) disable iff (ref_rst)
        match_o == match_aux_o); // R6

    AST_MATCH_GATED: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !men_s |-> (!match_o && !match_aux_o)); // R6

    AST_HOLD_STOPPED: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (!en_s && !blk_s && rstn_s && !pre_ld) |=> (cnt == $past(cnt))); // R5

    AST_STEP_ONE: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (tick && !blk_s && rstn_s && !(rom_s && (|match_reg) && cnt == match_reg))
        |=> (cnt == $past(cnt) + ONE)); // R1

    AST_MATCH_CLEAR: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (tick && !blk_s && rstn_s && rom_s && (|match_reg) && cnt == match_reg)
        |=> (cnt == '0)); // R7

    AST_CLEAR_HELD: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (!rstn_s || blk_s) |=> (cnt == '0)); // R8

    AST_BLK_STRETCH: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $fell(blk_bit) |-> (blk_int ##1 blk_int)); // R3

    AST_OSC_MODE: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !osc_sel_o |-> (osc_mode_o == 2'b00)); // R9

endmodule

bind rtc_match_counter rtc_match_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .bus_clk     (bus_clk),
    .bus_rst     (bus_rst),
    .ref_clk     (ref_clk),
    .ref_rst     (ref_rst),
    .blk_bit     (ctrl_q.blk_rst),
    .blk_int     (blk_int),
    .tick        (tick),
    .en_s        (rc_s.cnt_en),
    .blk_s       (rc_s.blk_rst),
    .rstn_s      (rc_s.cnt_rst_n),
    .rom_s       (rc_s.rst_on_match),
    .men_s       (rc_s.match_en),
    .pre_ld      (pre_ld),
    .cnt         (count_o),
    .match_reg   (match_q),
    .match_o     (match_o),
    .match_aux_o (match_aux_o),
    .osc_sel_o   (osc_sel_o),
    .osc_mode_o  (osc_mode_o)
);

// File: tb/rtc_match_counter_tb.sv
`timescale 1ns/100ps
module rtc_match_counter_tb;

    localparam int CNT_W = 40;
    localparam int PDIV  = 8;
    localparam int FIRST = 4;

    logic             bus_clk = 1'b0;
    logic             ref_clk = 1'b0;
    logic             bus_rst = 1'b1;
    logic             ref_rst = 1'b1;
    logic             wr_en   = 1'b0;
    logic [1:0]       wr_sel  = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count_o;
    logic             match_o;
    logic             match_aux_o;
    logic [1:0]       osc_mode_o;
    logic             osc_sel_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 bus_clk = ~bus_clk;
    always #7   ref_clk = ~ref_clk;

    rtc_match_counter #(
        .CNT_W(CNT_W), .PRESC_DIV(PDIV), .FIRST_TICK(FIRST), .SYNC_STAGES(2)
    ) u_dut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ref_clk(ref_clk), .ref_rst(ref_rst),
        .count_o(count_o), .match_o(match_o), .match_aux_o(match_aux_o),
        .osc_mode_o(osc_mode_o), .osc_sel_o(osc_sel_o)
    );

    // Control bits
    localparam logic [CNT_W-1:0] C_BLK = 40'h80;
    localparam logic [CNT_W-1:0] C_EN  = 40'h40;
    localparam logic [CNT_W-1:0] C_MEN = 40'h20;
    localparam logic [CNT_W-1:0] C_ROM = 40'h04;
    localparam logic [CNT_W-1:0] C_RN  = 40'h02;
    localparam logic [CNT_W-1:0] C_OSC = 40'h01;

    task automatic chk(input bit ok, input string req,
                       input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [CNT_W-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_change(input logic [CNT_W-1:0] old, input int maxn, output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (count_o == old && n < maxn);
    endtask

    // Stop, then preset a value while disabled
    task automatic park(input logic [CNT_W-1:0] v);
        bus_wr(2'd0, C_RN);
        wait_ref(6);
        bus_wr(2'd2, v);
        wait_ref(6);
    endtask

    task automatic t_reset;
        chk(count_o == '0, "R2 reset count", count_o, '0);
        chk(!match_o && !match_aux_o, "R2 reset match", {match_o, match_aux_o}, 0);
        chk(osc_mode_o == 2'b00 && !osc_sel_o, "R2 reset osc", {osc_mode_o, osc_sel_o}, 0);
    endtask

    task automatic t_osc;
        bus_wr(2'd0, 40'h18);
        chk(osc_mode_o == 2'b00 && !osc_sel_o, "R9 mode masked", {osc_mode_o, osc_sel_o}, 0);
        bus_wr(2'd0, 40'h10 | C_OSC);
        chk(osc_mode_o == 2'b10 && osc_sel_o, "R9 mode passed", {osc_mode_o, osc_sel_o}, 3'b101);
        bus_wr(2'd3, 40'h00);
        chk(osc_mode_o == 2'b10 && osc_sel_o, "R9 sel3 ignored", {osc_mode_o, osc_sel_o}, 3'b101);
    endtask

    task automatic t_first_tick;
        int n;
        park(40'd100);
        chk(count_o == 40'd100, "R5 preset while disabled", count_o, 40'd100);
        bus_wr(2'd0, C_EN | C_RN);
        wait_change(40'd100, 50, n);
        chk(n >= FIRST + 1 && n <= FIRST + 3, "R4 first tick delay", 40'(n), 40'(FIRST + 2));
        chk(count_o == 40'd101, "R1 first value", count_o, 40'd101);
        wait_change(40'd101, 50, n);
        chk(n == PDIV, "R1 tick interval", 40'(n), 40'(PDIV));
        chk(count_o == 40'd102, "R1 second value", count_o, 40'd102);
    endtask

    task automatic t_hold_preset;
        logic [CNT_W-1:0] v;
        bus_wr(2'd2, 40'd5000);
        wait_ref(3 * PDIV);
        chk(count_o != 40'd5000 && count_o < 40'd5000, "R5 preset ignored when enabled",
            count_o, 40'd102);
        bus_wr(2'd0, C_RN);
        wait_ref(6);
        v = count_o;
        wait_ref(3 * PDIV);
        chk(count_o == v, "R5 hold when disabled", count_o, v);
    endtask

    task automatic t_cnt_clear;
        park(40'd77);
        bus_wr(2'd0, C_EN);
        wait_ref(6);
        chk(count_o == '0, "R8 clear", count_o, '0);
        wait_ref(3 * PDIV);
        chk(count_o == '0, "R8 held", count_o, '0);
    endtask

    task automatic t_blk;
        int n;
        park(40'd55);
        bus_wr(2'd0, C_BLK | C_EN | C_RN);
        wait_ref(6);
        chk(count_o == '0, "R3 block reset clears", count_o, '0);
        wait_ref(3 * PDIV);
        chk(count_o == '0, "R3 block reset holds", count_o, '0);
        bus_wr(2'd0, C_EN | C_RN);
        wait_change('0, 60, n);
        chk(count_o == 40'd1, "R3 runs after release", count_o, 40'd1);
    endtask

    task automatic t_match_gate;
        bit seen;
        park(40'd10);
        bus_wr(2'd1, 40'd12);
        bus_wr(2'd0, C_EN | C_RN);
        seen = 0;
        for (int i = 0; i < 60 && count_o != 40'd13; i++) begin
            @(negedge ref_clk);
            if (match_o || match_aux_o) seen = 1;
        end
        chk(!seen, "R6 outputs gated off", 40'(seen), 0);
        park(40'd10);
        bus_wr(2'd0, C_MEN | C_EN | C_RN);
        for (int i = 0; i < 60 && !match_o; i++) @(negedge ref_clk);
        chk(match_o && match_aux_o && count_o == 40'd12, "R6 both outputs on equal",
            count_o, 40'd12);
        wait_ref(PDIV);
        chk(!match_o && !match_aux_o && count_o == 40'd13, "R6 outputs drop after",
            count_o, 40'd13);
    endtask

    task automatic t_rom;
        int n;
        park(40'd20);
        bus_wr(2'd1, 40'd22);
        bus_wr(2'd0, C_ROM | C_EN | C_RN);
        for (int i = 0; i < 60 && count_o != 40'd22; i++) @(negedge ref_clk);
        wait_change(40'd22, 50, n);
        chk(count_o == '0 && n == PDIV, "R7 clear on match", count_o, '0);
        park('0);
        bus_wr(2'd1, '0);
        bus_wr(2'd0, C_ROM | C_EN | C_RN);
        wait_ref(3 * PDIV + FIRST + 6);
        chk(count_o >= 40'd2, "R7 zero match disables clear", count_o, 40'd3);
    endtask

    task automatic t_wrap;
        int n;
        park({CNT_W{1'b1}} - 40'd1);
        bus_wr(2'd0, C_EN | C_RN);
        wait_change({CNT_W{1'b1}} - 40'd1, 50, n);
        chk(count_o == {CNT_W{1'b1}}, "R10 reaches all ones", count_o, {CNT_W{1'b1}});
        wait_change({CNT_W{1'b1}}, 50, n);
        chk(count_o == '0, "R10 wraps to zero", count_o, '0);
    endtask

    task automatic t_e1000;
        int n;
        park(40'hE1000 - 40'd2);
        bus_wr(2'd1, 40'hE1000);
        bus_wr(2'd0, C_MEN | C_EN | C_RN);
        wait_change(40'hE1000 - 40'd2, 50, n);
        chk(count_o == 40'hE0FFF && !match_o, "R11 one before match", count_o, 40'hE0FFF);
        n = 0;
        for (int i = 0; i < 50 && !match_o; i++) begin
            @(negedge ref_clk);
            n++;
        end
        chk(n == PDIV && count_o == 40'hE1000 && match_aux_o, "R11 match after one period",
            40'(n), 40'(PDIV));
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge ref_clk);
        @(negedge bus_clk);
        bus_rst = 1'b0;
        @(negedge ref_clk);
        ref_rst = 1'b0;
        wait_ref(2);
        t_reset();
        t_osc();
        t_first_tick();
        t_hold_preset();
        t_cnt_clear();
        t_blk();
        t_match_gate();
        t_rom();
        t_wrap();
        t_e1000();
        finish_run();
    end

endmodule